// File: doc/BRIEF.md
# Skewed-Read Dual-Port Matrix Buffer

This block is an on-chip store for matrices of signed 16-bit fixed-point words (eight integer bits, eight fraction bits). The store is organised as rows, and each row holds one word per lane. A write port takes one whole row per cycle, either from the host side or from the element-wise pipeline. A separate read port runs at the same time and streams a block of rows out to the edge of a systolic array.

The read stream is skewed for systolic entry: lane k carries the same logical step k cycles later than lane 0, and its valid flag follows the same delay. A read command carries a base row, a step count and a transpose flag. A plain read emits one stored row per step. A transposed read takes the square block of rows base..base+LANES-1 and emits one stored column per step, so the matrix leaves the buffer transposed without being rewritten. Row addresses wrap modulo DEPTH, which must be a power of two.

The read controller is a three-state machine. S_IDLE waits for a command. An accepted command (rd_start high with a non-zero count) takes it to S_STREAM. S_STREAM issues one step per cycle, and after the last step it moves to S_DRAIN. S_DRAIN waits LANES cycles for the skew pipeline to empty, then returns to S_IDLE and raises done for one cycle. No other transitions exist.

Top module: `skew_rd_buf`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, busy, done, every lane_valid bit and all of lane_data are zero.
- R2: A cycle with wr_en high stores wr_data as row wr_row. Word k of a row sits at bits [16k+15:16k] of wr_data and of lane_data. In a plain read, step t puts word k of row base+t on lane k, with the sign kept.
- R3: If rd_start is accepted at clock edge E, lane 0 shows step 0 after edge E+1. Lane k shows step t after edge E+1+t+k, and lane_valid[k] is high exactly while lane k carries a step.
- R4: In a transposed read, step t puts word t of row base+k on lane k. The step count is clamped to LANES.
- R5: busy is high from the edge that accepts a command until done. done is high for exactly one cycle, starting at edge E+n+LANES where n is the effective step count, and busy is low during that cycle.
- R6: rd_start has no effect while busy is high. A command with a count of zero is not accepted.
- R7: When a row is written in the same cycle that the read port samples it, the read returns the old contents. Later reads return the new row.
- R8: lane_data for lane k is zero whenever lane_valid[k] is low.
- R9: Row addresses base+t (plain) and base+k (transposed) wrap modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Write one row this cycle |
| wr_row | input | $clog2(DEPTH) | Row address of the write |
| wr_data | input | LANES*DW | Row contents, word k in slice k |
| rd_start | input | 1 | Read command strobe |
| rd_base | input | $clog2(DEPTH) | First row of the read |
| rd_count | input | $clog2(DEPTH)+1 | Number of steps to stream |
| rd_transpose | input | 1 | Emit columns instead of rows |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle end-of-read pulse |
| lane_data | output | LANES*DW | Skewed lane words, lane k in slice k |
| lane_valid | output | LANES | Per-lane valid, skewed like the data |

## Verification
The bench builds the block with LANES=4 and DEPTH=8. With only eight rows, a base near the top wraps within a single command, so both plain and transposed reads cross the top of the store (R9). Four lanes give a skew of up to three cycles, which is enough to see lanes overlap and drain at their own times. A transposed request for six steps exercises the clamp to the lane count.

// File: rtl/skb_pkg.sv
package skb_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_STREAM = 2'd1,
        S_DRAIN  = 2'd2
    } rd_state_t;
endpackage

// File: rtl/skb_ctrl.sv
module skb_ctrl
    import skb_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [$clog2(DEPTH)-1:0]   base,
    input  logic [$clog2(DEPTH):0]     count,
    input  logic                       transpose,
    output logic                       issue,
    output logic [$clog2(DEPTH)-1:0]   issue_base,
    output logic [$clog2(DEPTH):0]     issue_step,
    output logic                       issue_tr,
    output logic                       busy,
    output logic                       done
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam int LW = $clog2(LANES) + 1;

    rd_state_t      state_q, state_d;
    logic [AW-1:0]  base_q;
    logic [CW-1:0]  cnt_q, step_q;
    logic [LW-1:0]  dcnt_q;
    logic           tr_q, done_q;
    logic [CW-1:0]  eff_cnt;
    logic           accept;

    // transposed reads cover at most one square block
    assign eff_cnt = (transpose && (count > CW'(LANES))) ? CW'(LANES) : count;
    assign accept  = start && (count != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_STREAM;
            S_STREAM: if (step_q == cnt_q - CW'(1)) state_d = S_DRAIN;
            S_DRAIN:  if (dcnt_q == LW'(LANES - 1)) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= S_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
            step_q  <= '0;
            dcnt_q  <= '0;
            tr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == S_DRAIN) && (state_d == S_IDLE);
            unique case (state_q)
                S_IDLE: if (accept) begin
                    base_q <= base;
                    cnt_q  <= eff_cnt;
                    tr_q   <= transpose;
                    step_q <= '0;
                end
                S_STREAM: begin
                    step_q <= step_q + CW'(1);
                    dcnt_q <= '0;
                end
                S_DRAIN:  dcnt_q <= dcnt_q + LW'(1);
                default:  ;
            endcase
        end
    end

    always_comb begin
        issue      = (state_q == S_STREAM);
        issue_base = base_q;
        issue_step = step_q;
        issue_tr   = tr_q;
        busy       = (state_q != S_IDLE);
        done       = done_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                        // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                        // R5
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && count == '0) |=> !busy);             // R6
endmodule

// File: rtl/skb_store.sv
module skb_store #(
    parameter int LANES = 4,
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_row,
    input  logic [LANES*DW-1:0]        wr_data,
    input  logic                       issue,
    input  logic [$clog2(DEPTH)-1:0]   base,
    input  logic [$clog2(DEPTH):0]     step,
    input  logic                       tr,
    output logic [LANES*DW-1:0]        row_data,
    output logic                       row_valid
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [DW-1:0]       mem_q [DEPTH][LANES];
    logic [LANES*DW-1:0] gather;
    logic [AW-1:0]       rsel;
    logic [LW-1:0]       csel;

    // storage: the read below sees pre-write contents in a colliding cycle
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int r = 0; r < DEPTH; r++)
                for (int k = 0; k < LANES; k++)
                    mem_q[r][k] <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < LANES; k++)
                mem_q[wr_row][k] <= wr_data[k*DW +: DW];
        end
    end

    // plain: row base+step, word k; transposed: row base+k, word step
    always_comb begin
        gather = '0;
        rsel   = '0;
        csel   = '0;
        for (int k = 0; k < LANES; k++) begin
            rsel = tr ? (base + AW'(k)) : (base + step[AW-1:0]);
            csel = tr ? step[LW-1:0] : LW'(k);
            gather[k*DW +: DW] = mem_q[rsel][csel];
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            row_data  <= '0;
            row_valid <= 1'b0;
        end else begin
            row_data  <= issue ? gather : '0;
            row_valid <= issue;
        end
    end
endmodule

// File: rtl/skb_skew.sv
module skb_skew #(
    parameter int LANES = 4,
    parameter int DW    = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LANES*DW-1:0]   row_data,
    input  logic                  row_valid,
    output logic [LANES*DW-1:0]   lane_data,
    output logic [LANES-1:0]      lane_valid
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == 0) begin : g_direct
            assign lane_data[DW-1:0] = row_data[DW-1:0];
            assign lane_valid[0]     = row_valid;
        end else begin : g_delay
            logic [DW-1:0] dq [k];
            logic          vq [k];
            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    for (int j = 0; j < k; j++) begin
                        dq[j] <= '0;
                        vq[j] <= 1'b0;
                    end
                end else begin
                    dq[0] <= row_data[k*DW +: DW];
                    vq[0] <= row_valid;
                    for (int j = 1; j < k; j++) begin
                        dq[j] <= dq[j-1];
                        vq[j] <= vq[j-1];
                    end
                end
            end
            assign lane_data[k*DW +: DW] = dq[k-1];
            assign lane_valid[k]         = vq[k-1];
        end

        AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
            !lane_valid[k] |-> (lane_data[k*DW +: DW] == '0));  // R8
    end
endmodule

// File: rtl/skew_rd_buf.sv
module skew_rd_buf #(
    parameter int LANES = 4,
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_row,
    input  logic [LANES*DW-1:0]        wr_data,
    input  logic                       rd_start,
    input  logic [$clog2(DEPTH)-1:0]   rd_base,
    input  logic [$clog2(DEPTH):0]     rd_count,
    input  logic                       rd_transpose,
    output logic                       busy,
    output logic                       done,
    output logic [LANES*DW-1:0]        lane_data,
    output logic [LANES-1:0]           lane_valid
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic                issue, issue_tr, row_valid;
    logic [AW-1:0]       issue_base;
    logic [CW-1:0]       issue_step;
    logic [LANES*DW-1:0] row_data;

    skb_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .start(rd_start), .base(rd_base),
        .count(rd_count), .transpose(rd_transpose), .issue(issue),
        .issue_base(issue_base), .issue_step(issue_step),
        .issue_tr(issue_tr), .busy(busy), .done(done)
    );

    skb_store #(.LANES(LANES), .DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row),
        .wr_data(wr_data), .issue(issue), .base(issue_base),
        .step(issue_step), .tr(issue_tr), .row_data(row_data),
        .row_valid(row_valid)
    );

    skb_skew #(.LANES(LANES), .DW(DW)) u_skew (
        .clk(clk), .rst(rst), .row_data(row_data), .row_valid(row_valid),
        .lane_data(lane_data), .lane_valid(lane_valid)
    );

    AST_LANE0_LEADS: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> lane_valid[0]);                         // R3
    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (|lane_valid) |-> busy);                                // R5
    AST_LAST_LANE_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(lane_valid[LANES-1]) |-> done);                   // R5
endmodule

// File: tb/skew_rd_buf_bench.sv
module skew_rd_buf_bench;
    localparam int L  = 4;
    localparam int D  = 8;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_row = '0;
    logic [L*DW-1:0] wr_data = '0;
    logic            rd_start = 1'b0;
    logic [2:0]      rd_base = '0;
    logic [3:0]      rd_count = '0;
    logic            rd_transpose = 1'b0;
    logic            busy, done;
    logic [L*DW-1:0] lane_data;
    logic [L-1:0]    lane_valid;

    int n_run  = 0;
    int n_fail = 0;
    logic [DW-1:0] model [D][L];

    skew_rd_buf #(.LANES(L), .DW(DW), .DEPTH(D)) u_skew_rd_buf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row),
        .wr_data(wr_data), .rd_start(rd_start), .rd_base(rd_base),
        .rd_count(rd_count), .rd_transpose(rd_transpose), .busy(busy),
        .done(done), .lane_data(lane_data), .lane_valid(lane_valid)
    );

    always #10ns clk = ~clk;

    // vectors: base, count, transpose
    localparam int NV = 6;
    localparam int VB [NV] = '{0, 2, 6, 1, 0, 5};
    localparam int VC [NV] = '{3, 1, 4, 4, 6, 2};
    localparam int VT [NV] = '{0, 0, 0, 1, 1, 1};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int r, input int k, input int s);
        return DW'(r * 1000 + k * 77 - 2000 + s * 3);
    endfunction

    task automatic write_row(input int r, input int s);
        @(negedge clk);
        wr_en  = 1'b1;
        wr_row = 3'(r);
        for (int k = 0; k < L; k++) begin
            wr_data[k*DW +: DW] = pat(r, k, s);
            model[r][k] = pat(r, k, s);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // dup: extra start mid-stream; coll: write row base while it is read
    task automatic run_read(input int b, input int n, input bit tr,
                            input bit dup, input bit coll);
        int eff;
        int t;
        bit vexp;
        logic [DW-1:0] dexp;
        logic [DW-1:0] newrow [L];
        eff = (tr && n > L) ? L : n;
        @(negedge clk);
        rd_start = 1'b1; rd_base = 3'(b); rd_count = 4'(n); rd_transpose = tr;
        @(negedge clk);
        rd_start = 1'b0;
        chk(busy == 1'b1, "R5 busy after accept", int'(busy), 1);
        if (coll) begin
            wr_en  = 1'b1;
            wr_row = 3'(b);
            for (int k = 0; k < L; k++) begin
                newrow[k] = pat(b, k, 9);
                wr_data[k*DW +: DW] = newrow[k];
            end
        end
        for (int c = 1; c <= eff + L; c++) begin
            @(negedge clk);
            for (int k = 0; k < L; k++) begin
                t = c - 1 - k;
                vexp = (t >= 0) && (t < eff);
                if (!vexp)    dexp = '0;
                else if (tr)  dexp = model[(b + k) % D][t];
                else          dexp = model[(b + t) % D][k];
                chk(lane_valid[k] == vexp, "R3 lane valid skew",
                    int'(lane_valid[k]), int'(vexp));
                chk(lane_data[k*DW +: DW] == dexp,
                    tr ? "R4 R9 transposed lane data" : "R2 R7 R8 R9 lane data",
                    int'(lane_data[k*DW +: DW]), int'(dexp));
            end
            chk(done == (c == eff + L), "R5 done timing", int'(done), int'(c == eff + L));
            chk(busy == (c < eff + L), "R5 busy span", int'(busy), int'(c < eff + L));
            if (coll && c == 1) begin
                wr_en = 1'b0;
            end
            if (dup && c == 1) begin
                rd_start = 1'b1; rd_base = 3'd3; rd_count = 4'd5; rd_transpose = 1'b0;
            end
            if (dup && c == 2) rd_start = 1'b0;
        end
        if (coll)
            for (int k = 0; k < L; k++) model[b][k] = newrow[k];
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(busy == 1'b0 && done == 1'b0 && lane_valid == '0,
                "R6 idle after read", int'({busy, done, lane_valid}), 0);
        end
    endtask

    initial begin
        #(20ns * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        #35ns;
        chk(busy == 1'b0 && done == 1'b0, "R1 reset ctl", int'({busy, done}), 0);
        chk(lane_valid == '0 && lane_data == '0, "R1 reset lanes", int'(lane_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && lane_valid == '0 && lane_data == '0,
            "R1 after release", int'({busy, done, lane_valid}), 0);

        // R2: fill every row
        for (int r = 0; r < D; r++) write_row(r, 0);

        // vector table walk (R2 R3 R4 R5 R8 R9)
        for (int i = 0; i < NV; i++) run_read(VB[i], VC[i], VT[i] != 0, 1'b0, 1'b0);

        // R6: second start while busy is ignored
        run_read(0, 2, 1'b0, 1'b1, 1'b0);

        // R6: zero count is not accepted
        @(negedge clk);
        rd_start = 1'b1; rd_base = 3'd1; rd_count = 4'd0; rd_transpose = 1'b0;
        @(negedge clk);
        rd_start = 1'b0;
        for (int c = 0; c < 4; c++) begin
            chk(busy == 1'b0 && done == 1'b0 && lane_valid == '0,
                "R6 zero count ignored", int'({busy, done, lane_valid}), 0);
            @(negedge clk);
        end

        // R7: collision returns old row, later read returns new row
        run_read(2, 1, 1'b0, 1'b0, 1'b1);
        run_read(2, 1, 1'b0, 1'b0, 1'b0);

        // R9: plain wrap across the top with the full depth
        run_read(7, 8, 1'b0, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule